// File: doc/BRIEF.md
# Banked Inner-Attribute Remap Register

This block keeps a 32-bit register that re-maps a 3-bit memory region type into a 2-bit inner cacheability attribute. Two copies of the register are held: one for the secure world and one for the non-secure world. Software reaches the register through a coprocessor-style access port. A request names the register with a 3-bit opcode field and two 4-bit register-number fields, and carries its privilege level and security state. The block answers each request in the same cycle: it returns read data, or it raises an undefined-exception pulse when the access is not allowed.

A separate lookup port serves the translation logic. It takes a 3-bit region-type index, formed from one type-extension bit and the cacheable and bufferable bits in that order, together with its own security-state select. It returns the 2-bit attribute held in the chosen copy. The reset contents make this lookup reproduce the default attribute mapping, so nothing is remapped until software writes the register.

Top module: `remap_attr_reg`

## Requirements
- R1: After reset both copies hold 0x000008E0. Reading back, field k for k = 0..6 holds 00, 00, 10, 11, 00, 10, 00.
- R2: The register is selected only when the opcode field is 0, the primary register number is 10 and the secondary register number is 2. Any other request reads 0, raises no exception and writes nothing.
- R3: A privileged request in secure state (ns = 0) reads or writes the secure copy.
- R4: A privileged request in non-secure state (ns = 1) reads or writes the non-secure copy and never changes the secure copy.
- R5: Any selected request in user mode (priv = 0) pulses the undefined-exception output in that cycle, reads 0 and leaves both copies unchanged.
- R6: A secure privileged write while the secure write-lock input is high pulses the undefined-exception output and leaves the secure copy unchanged. Secure reads and non-secure writes are unaffected by the lock.
- R7: Bits [31:14] always read as zero and ignore written values.
- R8: The lookup returns bits [2k+1:2k] of the chosen copy for index k = 0..6, and returns 00 for index 7. The attribute codes are 00 non-cacheable, 01 write-back with write-allocate, 10 write-through without write-allocate and 11 write-back without write-allocate.
- R9: The lookup uses its own ns select, not the access port's. A lookup in the cycle after a write returns the new value.
- R10: Read data appears combinationally in the cycle of the request. A write takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op | input | 3 | Opcode selector field |
| acc_prim | input | 4 | Primary register number |
| acc_sec | input | 4 | Secondary register number |
| acc_priv | input | 1 | 1 = privileged, 0 = user |
| acc_ns | input | 1 | Access security state, 1 = non-secure |
| acc_wdata | input | 32 | Write data |
| sec_wr_lock | input | 1 | Blocks secure writes when high |
| acc_rdata | output | 32 | Read data, 0 when no read is granted |
| acc_undef | output | 1 | Undefined-exception pulse |
| lk_ns | input | 1 | Lookup bank select, 1 = non-secure |
| lk_idx | input | 3 | Region-type index |
| lk_attr | output | 2 | Remapped inner attribute |

## Verification
The assertions check several rules on every cycle:
- a user-mode request raises the exception and freezes both copies;
- a locked secure write leaves the secure copy untouched;
- non-secure traffic never alters the secure copy;
- the upper bits read zero;
- an unselected request stays silent;
- index 7 yields 00.

Some behaviour only the bench scenarios can show: the actual values stored and read back, the reset image and its field decoding, the split between the two copies, and a lookup seeing a write in the very next cycle.

// File: rtl/remap_pkg.sv
// Package: shared widths, select constants and reset image for the
// banked attribute remap register. Assumes 2-bit fields, 7 live indices.
package remap_pkg;
    localparam int REG_W     = 32;
    localparam int FIELD_W   = 2;
    localparam int IDX_W     = 3;
    localparam int NUM_IDX   = 7;
    localparam int LIVE_W    = NUM_IDX * FIELD_W;
    localparam int NUM_BANKS = 2;
    localparam int OP_W      = 3;
    localparam int RN_W      = 4;

    localparam logic [OP_W-1:0] SEL_OP   = 3'd0;
    localparam logic [RN_W-1:0] SEL_PRIM = 4'd10;
    localparam logic [RN_W-1:0] SEL_SEC  = 4'd2;

    typedef enum logic [FIELD_W-1:0] {
        ATTR_NC    = 2'b00,
        ATTR_WB_WA = 2'b01,
        ATTR_WT    = 2'b10,
        ATTR_WB    = 2'b11
    } attr_e;

    // Reset attribute per index, chosen so the lookup matches the default map.
    function automatic attr_e reset_attr(input int k);
        case (k)
            2:       return ATTR_WT;
            3:       return ATTR_WB;
            5:       return ATTR_WT;
            default: return ATTR_NC;
        endcase
    endfunction

    // Reset image of the live bits, built from the per-index attributes.
    function automatic logic [LIVE_W-1:0] reset_image();
        logic [LIVE_W-1:0] v;
        v = '0;
        for (int k = 0; k < NUM_IDX; k++) v[k*FIELD_W +: FIELD_W] = reset_attr(k);
        return v;
    endfunction
endpackage

// File: rtl/remap_access_dec.sv
// Module: decodes an access request, applies the privilege and secure
// write-lock rules, and produces per-bank write enables and a read grant.
// Assumes bank 0 is secure, bank 1 non-secure (bank index = ns bit).
module remap_access_dec
    import remap_pkg::*;
(
    input  logic                 valid,
    input  logic                 write,
    input  logic [OP_W-1:0]      op,
    input  logic [RN_W-1:0]      prim,
    input  logic [RN_W-1:0]      sec,
    input  logic                 priv,
    input  logic                 ns,
    input  logic                 lock,
    output logic                 undef,
    output logic                 rd_en,
    output logic [NUM_BANKS-1:0] wr_en
);
    logic hit;
    logic deny;
    logic grant;

    // Register selection and permission check.
    always_comb begin
        hit   = valid && (op == SEL_OP) && (prim == SEL_PRIM) && (sec == SEL_SEC);
        deny  = !priv || (write && !ns && lock);
        undef = hit && deny;
        grant = hit && !deny;
        rd_en = grant && !write;
    end

    // One write enable per bank, steered by security state.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_wen
        assign wr_en[b] = grant && write && (ns == b[0]);
    end
endmodule

// File: rtl/remap_bank_store.sv
// Module: holds the live bits of each bank. Synchronous active-low reset
// loads the default image; unused upper bits are never stored.
module remap_bank_store
    import remap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] wr_en,
    input  logic [LIVE_W-1:0]    wdata,
    output logic [LIVE_W-1:0]    bank_q [NUM_BANKS]
);
    localparam logic [LIVE_W-1:0] RST_IMG = reset_image();

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Per-bank register: reset image, then load on its write enable.
        always_ff @(posedge clk) begin
            if (!rst_n)        bank_q[b] <= RST_IMG;
            else if (wr_en[b]) bank_q[b] <= wdata;
        end
    end
endmodule

// File: rtl/remap_attr_lookup.sv
// Module: picks the 2-bit attribute field for a region-type index out of
// one bank value. Indices at or beyond NUM_IDX return non-cacheable.
module remap_attr_lookup
    import remap_pkg::*;
(
    input  logic [LIVE_W-1:0]  bank,
    input  logic [IDX_W-1:0]   idx,
    output logic [FIELD_W-1:0] attr
);
    // Field multiplexer over the live indices.
    always_comb begin
        attr = ATTR_NC;
        for (int k = 0; k < NUM_IDX; k++) begin
            if (idx == IDX_W'(k)) attr = bank[k*FIELD_W +: FIELD_W];
        end
    end
endmodule

// File: rtl/remap_attr_reg.sv
// Module (top): banked inner-attribute remap register with a coprocessor
// access port and a combinational lookup port. Reads and lookups are
// same-cycle; writes land on the next clock edge.
module remap_attr_reg
    import remap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [OP_W-1:0]    acc_op,
    input  logic [RN_W-1:0]    acc_prim,
    input  logic [RN_W-1:0]    acc_sec,
    input  logic               acc_priv,
    input  logic               acc_ns,
    input  logic [REG_W-1:0]   acc_wdata,
    input  logic               sec_wr_lock,
    output logic [REG_W-1:0]   acc_rdata,
    output logic               acc_undef,
    input  logic               lk_ns,
    input  logic [IDX_W-1:0]   lk_idx,
    output logic [FIELD_W-1:0] lk_attr
);
    logic                 rd_en;
    logic [NUM_BANKS-1:0] wr_en;
    logic [LIVE_W-1:0]    bank_q [NUM_BANKS];
    logic [LIVE_W-1:0]    sec_val;
    logic [LIVE_W-1:0]    ns_val;
    logic [LIVE_W-1:0]    lk_bank;
    logic                 wdata_unused;

    assign wdata_unused = ^acc_wdata[REG_W-1:LIVE_W];

    remap_access_dec u_dec (
        .valid (acc_valid),
        .write (acc_write),
        .op    (acc_op),
        .prim  (acc_prim),
        .sec   (acc_sec),
        .priv  (acc_priv),
        .ns    (acc_ns),
        .lock  (sec_wr_lock),
        .undef (acc_undef),
        .rd_en (rd_en),
        .wr_en (wr_en)
    );

    remap_bank_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wdata  (acc_wdata[LIVE_W-1:0]),
        .bank_q (bank_q)
    );

    assign sec_val = bank_q[0];
    assign ns_val  = bank_q[1];

    // Read path: zero-extend the selected bank when a read is granted.
    always_comb begin
        acc_rdata = '0;
        if (rd_en) acc_rdata[LIVE_W-1:0] = acc_ns ? ns_val : sec_val;
    end

    // Lookup bank choice follows the lookup port's own security select.
    assign lk_bank = lk_ns ? ns_val : sec_val;

    remap_attr_lookup u_lookup (
        .bank (lk_bank),
        .idx  (lk_idx),
        .attr (lk_attr)
    );
endmodule

// File: rtl/remap_attr_chk.sv
// Module: property checker for remap_attr_reg, attached by bind. Observes
// ports and the two bank values; drives nothing.
module remap_attr_chk
    import remap_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic               acc_write,
    input logic [OP_W-1:0]    acc_op,
    input logic [RN_W-1:0]    acc_prim,
    input logic [RN_W-1:0]    acc_sec,
    input logic               acc_priv,
    input logic               acc_ns,
    input logic               sec_wr_lock,
    input logic [REG_W-1:0]   acc_rdata,
    input logic               acc_undef,
    input logic [IDX_W-1:0]   lk_idx,
    input logic [FIELD_W-1:0] lk_attr,
    input logic [LIVE_W-1:0]  sec_val,
    input logic [LIVE_W-1:0]  ns_val
);
    logic sel;
    assign sel = acc_valid && acc_op == SEL_OP && acc_prim == SEL_PRIM && acc_sec == SEL_SEC;

    // R5
    user_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel && !acc_priv |-> acc_undef);
    // R5
    user_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel && !acc_priv |=> $stable(sec_val) && $stable(ns_val));
    // R6
    lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel && acc_write && acc_priv && !acc_ns && sec_wr_lock |=> $stable(sec_val));
    // R4
    ns_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel && acc_ns |=> $stable(sec_val));
    // R7
    hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rdata[REG_W-1:LIVE_W] == '0);
    // R8
    idx_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_idx == 3'd7 |-> lk_attr == 2'b00);
    // R2
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> !acc_undef && acc_rdata == '0);
endmodule

bind remap_attr_reg remap_attr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_op      (acc_op),
    .acc_prim    (acc_prim),
    .acc_sec     (acc_sec),
    .acc_priv    (acc_priv),
    .acc_ns      (acc_ns),
    .sec_wr_lock (sec_wr_lock),
    .acc_rdata   (acc_rdata),
    .acc_undef   (acc_undef),
    .lk_idx      (lk_idx),
    .lk_attr     (lk_attr),
    .sec_val     (sec_val),
    .ns_val      (ns_val)
);

// File: tb/test_remap_attr_reg.sv
`timescale 1ns/1ps
module test_remap_attr_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_priv = 1'b0, acc_ns = 1'b0;
    logic [2:0]  acc_op = '0;
    logic [3:0]  acc_prim = '0, acc_sec = '0;
    logic [31:0] acc_wdata = '0;
    logic        sec_wr_lock = 1'b0;
    logic [31:0] acc_rdata;
    logic        acc_undef;
    logic        lk_ns = 1'b0;
    logic [2:0]  lk_idx = '0;
    logic [1:0]  lk_attr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    remap_attr_reg i_remap_attr_reg (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_op(acc_op), .acc_prim(acc_prim), .acc_sec(acc_sec), .acc_priv(acc_priv),
        .acc_ns(acc_ns), .acc_wdata(acc_wdata), .sec_wr_lock(sec_wr_lock),
        .acc_rdata(acc_rdata), .acc_undef(acc_undef), .lk_ns(lk_ns),
        .lk_idx(lk_idx), .lk_attr(lk_attr)
    );

    typedef struct packed {
        logic        wr;
        logic        priv;
        logic        ns;
        logic        lock;
        logic [2:0]  op;
        logic [3:0]  prim;
        logic [3:0]  sec;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        exp_undef;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b0,1'b0,3'd0,4'd10,4'd2,32'h0,        32'h000008E0,1'b0,8'd1},
        '{1'b1,1'b1,1'b0,1'b0,3'd0,4'd10,4'd2,32'hFFFF1234, 32'h0,       1'b0,8'd3},
        '{1'b0,1'b1,1'b0,1'b0,3'd0,4'd10,4'd2,32'h0,        32'h00001234,1'b0,8'd7},
        '{1'b0,1'b1,1'b1,1'b0,3'd0,4'd10,4'd2,32'h0,        32'h000008E0,1'b0,8'd4},
        '{1'b1,1'b1,1'b1,1'b0,3'd0,4'd10,4'd2,32'h00002AAA, 32'h0,       1'b0,8'd4},
        '{1'b0,1'b1,1'b1,1'b0,3'd0,4'd10,4'd2,32'h0,        32'h00002AAA,1'b0,8'd10},
        '{1'b0,1'b0,1'b1,1'b0,3'd0,4'd10,4'd2,32'h0,        32'h0,       1'b1,8'd5},
        '{1'b1,1'b0,1'b0,1'b0,3'd0,4'd10,4'd2,32'h0,        32'h0,       1'b1,8'd5},
        '{1'b0,1'b1,1'b0,1'b0,3'd0,4'd10,4'd2,32'h0,        32'h00001234,1'b0,8'd5},
        '{1'b1,1'b1,1'b0,1'b1,3'd0,4'd10,4'd2,32'h0,        32'h0,       1'b1,8'd6},
        '{1'b0,1'b1,1'b0,1'b1,3'd0,4'd10,4'd2,32'h0,        32'h00001234,1'b0,8'd6},
        '{1'b1,1'b1,1'b1,1'b1,3'd0,4'd10,4'd2,32'h00000155, 32'h0,       1'b0,8'd6},
        '{1'b0,1'b1,1'b1,1'b0,3'd0,4'd10,4'd2,32'h0,        32'h00000155,1'b0,8'd6},
        '{1'b1,1'b1,1'b0,1'b0,3'd0,4'd9, 4'd2,32'h0,        32'h0,       1'b0,8'd2},
        '{1'b0,1'b1,1'b0,1'b0,3'd0,4'd10,4'd2,32'h0,        32'h00001234,1'b0,8'd2},
        '{1'b0,1'b0,1'b0,1'b0,3'd0,4'd10,4'd3,32'h0,        32'h0,       1'b0,8'd2},
        '{1'b0,1'b1,1'b0,1'b0,3'd1,4'd10,4'd2,32'h0,        32'h0,       1'b0,8'd2}
    };

    // Requirement-derived field extraction: index 7 yields 00.
    function automatic logic [1:0] fld(input logic [31:0] v, input int k);
        return (k >= 7) ? 2'b00 : v[2*k +: 2];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input vec_t v);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = v.wr; acc_priv = v.priv; acc_ns = v.ns;
        sec_wr_lock = v.lock; acc_op = v.op; acc_prim = v.prim; acc_sec = v.sec;
        acc_wdata = v.wdata;
        #1;
        chk($sformatf("R%0d rdata", v.req), acc_rdata, v.exp_rd);
        chk($sformatf("R%0d undef", v.req), {31'b0, acc_undef}, {31'b0, v.exp_undef});
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; sec_wr_lock = 1'b0;
    endtask

    task automatic look_all(input logic ns, input logic [31:0] img, input string req);
        for (int k = 0; k < 8; k++) begin
            lk_ns = ns; lk_idx = 3'(k);
            #0.2;
            chk(req, {30'b0, lk_attr}, {30'b0, fld(img, k)});
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 and R8: reset image decoded by the lookup in both banks
        @(negedge clk);
        look_all(1'b0, 32'h000008E0, "R1 R8 secure lookup at reset");
        look_all(1'b1, 32'h000008E0, "R1 R8 nonsecure lookup at reset");

        // Table walk: R2 R3 R4 R5 R6 R7 R10
        for (int i = 0; i < NV; i++) acc(VECS[i]);
        idle();

        // R8: lookups of the written images
        look_all(1'b0, 32'h00001234, "R8 secure lookup");
        look_all(1'b1, 32'h00000155, "R8 nonsecure lookup");

        // R9: lookup select independent of access ns, sees write next cycle
        acc('{1'b1,1'b1,1'b1,1'b0,3'd0,4'd10,4'd2,32'h00003FFF,32'h0,1'b0,8'd9});
        lk_ns = 1'b1; lk_idx = 3'd3;
        #0.2;
        chk("R9 before edge", {30'b0, lk_attr}, 32'h1);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_ns = 1'b0; acc_priv = 1'b1;
        lk_ns = 1'b1; lk_idx = 3'd6;
        #0.2;
        chk("R9 next cycle", {30'b0, lk_attr}, 32'h3);
        chk("R9 access ns not used", acc_rdata, 32'h00001234);
        lk_ns = 1'b0;
        #0.2;
        chk("R9 secure bank lookup", {30'b0, lk_attr}, 32'h1);
        idle();

        // R1: reset mid-run restores both copies
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        acc('{1'b0,1'b1,1'b0,1'b0,3'd0,4'd10,4'd2,32'h0,32'h000008E0,1'b0,8'd1});
        acc('{1'b0,1'b1,1'b1,1'b0,3'd0,4'd10,4'd2,32'h0,32'h000008E0,1'b0,8'd1});
        idle();
        @(negedge clk);
        finish_run();
    end
endmodule